// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides whether a received frame should be kept, based only on its 48-bit destination address. A single-cycle start strobe samples the destination, an 8-bit receive-configuration byte, the station's own 48-bit address and a 64-bit group hash mask. The block then steps a CRC-32 register through all 48 destination bits, one bit per clock. When the hash is complete it reports whether the frame is accepted, and a flag that marks group (multicast or broadcast) destinations.

Four rules apply. Promiscuous mode accepts everything. The all-ones broadcast destination has its own enable. Other group destinations need the multicast enable and a set bit in the hash mask, at the position chosen by six bits of the CRC. Individual destinations must equal the station address exactly. Every start takes the same number of cycles, whichever rule decides.

Address byte 0 is the first byte on the wire. It sits in bits [7:0] of each 48-bit port, byte k in bits [8k+7:8k].

Top module: `rx_dest_filter`

## Requirements
- R1: A start_i sampled while the block is idle makes busy_o high from the next cycle. Exactly 49 rising edges after the edge that sampled start_i, done_o goes high for one cycle and busy_o falls.
- R2: start_i and every data input are ignored while busy_o is high. The result reflects only the values sampled with the accepted start.
- R3: When configuration bit 4 is set, the frame is accepted whatever its destination.
- R4: When bit 4 is clear, an all-ones destination is accepted if and only if configuration bit 2 is set. This rule takes priority over the group-address rule.
- R5: When bit 4 is clear, a destination that is not all ones and has bit 0 of byte 0 set is rejected if configuration bit 3 is clear.
- R6: With bit 3 set, such a group destination is accepted if and only if hash_mask_i[idx] is set, where idx = crc[31:26]. Mask byte idx/8 occupies bits [8(idx/8)+7 : 8(idx/8)], and the bit within it is idx%8. The CRC register starts at all ones and takes destination bits 0..47, bit 0 first. At each bit, fb = crc[31] ^ bit, crc is shifted left by one, and when fb is 1 it is XORed with 0x04C11DB6 and its bit 0 is set to 1.
- R7: When bit 4 is clear and bit 0 of byte 0 is clear, the frame is accepted if and only if all 48 destination bits equal station_addr_i.
- R8: group_o, valid with done_o, equals bit 0 of destination byte 0, whether the frame is accepted or not.
- R9: After reset, busy_o, done_o, accept_o and group_o are all 0.
- R10: accept_o and group_o keep their values from done_o until the next done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled when idle |
| dest_addr_i | input | 48 | Destination address, byte 0 in [7:0] |
| rx_cfg_i | input | 8 | Receive configuration: bit 4 promiscuous, bit 3 multicast enable, bit 2 broadcast enable |
| station_addr_i | input | 48 | Own station address, byte 0 in [7:0] |
| hash_mask_i | input | 64 | Group hash mask, indexed by CRC bits [31:26] |
| busy_o | output | 1 | Evaluation in progress |
| done_o | output | 1 | One-cycle result strobe |
| accept_o | output | 1 | Frame accepted |
| group_o | output | 1 | Destination is a group address |

## Verification
The hardest case to reach is a group destination whose outcome depends on a single mask bit. Stimulus with a random mask almost never isolates the one hash position that matters. The bench computes the hash index itself, then runs the same destination twice: once with a mask holding only that bit, and once with every bit set except that one. It also restarts and changes every input while an evaluation is running, to show that only the first sampled set counts.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned ADDR_W      = 48;
  localparam int unsigned CFG_W       = 8;
  localparam int unsigned CRC_W       = 32;
  localparam int unsigned HASH_W      = 6;
  localparam logic [31:0] CRC_POLY    = 32'h04C11DB6;
  localparam int unsigned CFG_PROMISC = 4;
  localparam int unsigned CFG_MCAST   = 3;
  localparam int unsigned CFG_BCAST   = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_FINAL = 2'd2
  } rxf_state_e;
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int unsigned NBITS = 48,
  localparam int unsigned CNT_W = $clog2(NBITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             shift_o,
  output logic             finish_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] bit_idx_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBITS - 1);

  rxf_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_SHIFT;
        cnt_d   = '0;
      end
      ST_SHIFT: begin
        if (cnt_q == LAST) state_d = ST_FINAL;
        else               cnt_d   = cnt_q + CNT_W'(1);
      end
      ST_FINAL: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign load_o    = (state_q == ST_IDLE) && start_i;
  assign shift_o   = (state_q == ST_SHIFT);
  assign finish_o  = (state_q == ST_FINAL);
  assign busy_o    = (state_q != ST_IDLE);
  assign bit_idx_o = cnt_q;

  // R1
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  // R1
  final_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FINAL) |-> ($past(state_q) == ST_SHIFT && $past(cnt_q) == LAST));
  // R2
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && start_i && cnt_q != LAST) |=> (state_q == ST_SHIFT));
endmodule

// File: rtl/rxf_crc_serial.sv
module rxf_crc_serial
  import rxf_pkg::*;
#(
  parameter int unsigned    WIDTH = 32,
  parameter logic [WIDTH-1:0] POLY = WIDTH'(CRC_POLY)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic             data_i,
  output logic [WIDTH-1:0] crc_o
);
  logic [WIDTH-1:0] crc_q, shifted;
  logic             fb;

  assign fb      = crc_q[WIDTH-1] ^ data_i;
  assign shifted = {crc_q[WIDTH-2:0], 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '1;
    else if (load_i)  crc_q <= '1;
    else if (shift_i) crc_q <= fb ? ((shifted ^ POLY) | WIDTH'(1)) : shifted;
  end

  assign crc_o = crc_q;

  // R6
  crc_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (crc_q == '1));
  // R6
  crc_low_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> (crc_q[0] == ($past(crc_q[WIDTH-1]) ^ $past(data_i))));
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int unsigned AW = 48,
  parameter int unsigned HW = 6,
  localparam int unsigned MW = 1 << HW
) (
  input  logic [AW-1:0]    dest_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [AW-1:0]    station_i,
  input  logic [MW-1:0]    mask_i,
  input  logic [HW-1:0]    hash_idx_i,
  output logic             accept_o,
  output logic             group_o
);
  logic is_bcast, is_group, is_own;

  assign is_bcast = &dest_i;
  assign is_group = dest_i[0];
  assign is_own   = (dest_i == station_i);

  always_comb begin
    if (cfg_i[CFG_PROMISC])  accept_o = 1'b1;
    else if (is_bcast)       accept_o = cfg_i[CFG_BCAST];
    else if (is_group)       accept_o = cfg_i[CFG_MCAST] && mask_i[hash_idx_i];
    else                     accept_o = is_own;
  end

  assign group_o = is_group;
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned HW = HASH_W,
  parameter int unsigned CW = CRC_W,
  localparam int unsigned MW = 1 << HW,
  localparam int unsigned IW = $clog2(AW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    dest_addr_i,
  input  logic [CFG_W-1:0] rx_cfg_i,
  input  logic [AW-1:0]    station_addr_i,
  input  logic [MW-1:0]    hash_mask_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             accept_o,
  output logic             group_o
);
  logic          load, shift, finish;
  logic [IW-1:0] bit_idx;
  logic [CW-1:0] crc;
  logic          dec_accept, dec_group;

  logic [AW-1:0]    dest_q, sta_q;
  logic [CFG_W-1:0] cfg_q;
  logic [MW-1:0]    mask_q;
  logic             done_q, accept_q, group_q;

  rxf_ctrl #(.NBITS(AW)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .load_o(load), .shift_o(shift), .finish_o(finish),
    .busy_o, .bit_idx_o(bit_idx)
  );

  rxf_crc_serial #(.WIDTH(CW), .POLY(CW'(CRC_POLY))) u_crc (
    .clk_i, .rst_ni, .load_i(load), .shift_i(shift),
    .data_i(dest_q[bit_idx]), .crc_o(crc)
  );

  rxf_decide #(.AW(AW), .HW(HW)) u_decide (
    .dest_i(dest_q), .cfg_i(cfg_q), .station_i(sta_q), .mask_i(mask_q),
    .hash_idx_i(crc[CW-1 -: HW]),
    .accept_o(dec_accept), .group_o(dec_group)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dest_q <= '0;
      sta_q  <= '0;
      cfg_q  <= '0;
      mask_q <= '0;
    end else if (load) begin
      dest_q <= dest_addr_i;
      sta_q  <= station_addr_i;
      cfg_q  <= rx_cfg_i;
      mask_q <= hash_mask_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      accept_q <= 1'b0;
      group_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish) begin
        accept_q <= dec_accept;
        group_q  <= dec_group;
      end
    end
  end

  assign done_o   = done_q;
  assign accept_o = accept_q;
  assign group_o  = group_q;

  // R1
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R1
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));
  // R2
  hold_inputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(dest_q) && $stable(cfg_q) && $stable(mask_q) && $stable(sta_q)));
  // R3
  promisc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cfg_q[CFG_PROMISC]) |-> accept_o);
  // R4
  bcast_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !cfg_q[CFG_PROMISC] && (&dest_q) && !cfg_q[CFG_BCAST]) |-> !accept_o);
  // R5
  mcast_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !cfg_q[CFG_PROMISC] && !(&dest_q) && dest_q[0] && !cfg_q[CFG_MCAST]) |-> !accept_o);
  // R10
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !finish) |=> ($stable(accept_o) && $stable(group_o)));
endmodule

// File: tb/rx_dest_filter_bench.sv
module rx_dest_filter_bench;
  localparam logic [31:0] POLY = 32'h04C11DB6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [47:0] dest = '0, sta = '0;
  logic [7:0]  cfg = '0;
  logic [63:0] mask = '0;
  logic        busy, done, accept, group;
  string       cur_tag = "R1";

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rx_dest_filter u_rx_dest_filter (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .dest_addr_i(dest), .rx_cfg_i(cfg), .station_addr_i(sta), .hash_mask_i(mask),
    .busy_o(busy), .done_o(done), .accept_o(accept), .group_o(group)
  );

  function automatic int ref_idx(logic [47:0] d);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      logic f = c[31] ^ d[k];
      c = c << 1;
      if (f) c = (c ^ POLY) | 32'd1;
    end
    return int'(c[31:26]);
  endfunction

  function automatic logic ref_accept(logic [47:0] d, logic [7:0] c,
                                      logic [47:0] s, logic [63:0] m);
    if (c[4]) return 1'b1;
    if (d == {48{1'b1}}) return c[2];
    if (d[0]) return c[3] && m[ref_idx(d)];
    return d == s;
  endfunction

  // reference model, one step per clock
  int    m_cnt = -1;
  logic  m_busy = 0, m_done = 0, m_acc = 0, m_grp = 0;
  logic  m_pend_acc, m_pend_grp;
  string m_tag = "R1", m_pend_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = -1; m_busy = 0; m_done = 0; m_acc = 0; m_grp = 0;
    end else begin
      m_done = 0;
      if (m_cnt < 0) begin
        if (start) begin
          m_cnt = 0; m_busy = 1;
          m_pend_acc = ref_accept(dest, cfg, sta, mask);
          m_pend_grp = dest[0];
          m_pend_tag = cur_tag;
        end
      end else begin
        m_cnt++;
        if (m_cnt == 49) begin
          m_busy = 0; m_done = 1; m_cnt = -1;
          m_acc = m_pend_acc; m_grp = m_pend_grp; m_tag = m_pend_tag;
        end
      end
    end
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1", "busy_o", busy, m_busy);
      chk("R1", "done_o", done, m_done);
      chk(m_done ? m_tag : "R10", "accept_o", accept, m_acc);
      chk(m_done ? "R8" : "R10", "group_o", group, m_grp);
    end
  end

  task automatic run(logic [47:0] d, logic [7:0] c, logic [47:0] s,
                     logic [63:0] m, string tag);
    @(negedge clk);
    dest = d; cfg = c; sta = s; mask = m; cur_tag = tag; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (52) @(negedge clk);
  endtask

  localparam logic [47:0] OWN   = 48'h5634_1200_AB02;
  localparam logic [47:0] BCAST = {48{1'b1}};
  localparam logic [47:0] GRP   = 48'h0000_5E00_0001;

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    // R9
    chk("R9", "busy_o reset", busy, 1'b0);
    chk("R9", "done_o reset", done, 1'b0);
    chk("R9", "accept_o reset", accept, 1'b0);
    chk("R9", "group_o reset", group, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(48'h0011_2233_4400, 8'h10, OWN, '0, "R3");
    run(GRP, 8'h10, OWN, '0, "R3");
    run(BCAST, 8'h04, OWN, '0, "R4");
    run(BCAST, 8'h08, OWN, '1, "R4");
    run(GRP, 8'h04, OWN, '1, "R5");
    run(GRP, 8'h08, OWN, '1, "R6");
    run(GRP, 8'h08, OWN, '0, "R6");
    idx = ref_idx(GRP);
    run(GRP, 8'h08, OWN, 64'd1 << idx, "R6");
    run(GRP, 8'h08, OWN, ~(64'd1 << idx), "R6");
    idx = ref_idx(48'hCAFE_0000_0103);
    run(48'hCAFE_0000_0103, 8'h0C, OWN, 64'd1 << idx, "R6");
    run(OWN, 8'h00, OWN, '0, "R7");
    run(OWN ^ 48'h8000_0000_0000, 8'h0C, OWN, '1, "R7");
    run(OWN ^ 48'h0000_0000_0080, 8'h00, OWN, '1, "R7");
    run(48'h0000_0000_0002, 8'h1C, OWN, '0, "R8");

    // R2: change every input and restart while busy
    @(negedge clk);
    dest = OWN; cfg = 8'h00; sta = OWN; mask = '0; cur_tag = "R2"; start = 1'b1;
    @(negedge clk);
    repeat (10) @(negedge clk);
    dest = BCAST; cfg = 8'h10; sta = '0; mask = '1;
    repeat (5) @(negedge clk);
    dest = 48'h0011_2233_4455;
    repeat (34) @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    run(GRP, 8'h00, OWN, '1, "R5");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired t=%0t", $time);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule